// File: doc/BRIEF.md
# Inverted-Polarity Parallel Test-Bus Controller

This block links a simple synchronous host register port to an asynchronous, byte-wide test bus that serves up to sixteen addressed modules. The host picks a module, then starts one of three handshaked transfers: an initialize pulse, a byte write, or a byte read from one of eight sub-registers. The controller runs the Ready/strobe handshake and converts polarity at the boundary. Bus data, sub-address, select and strobe lines are active-low, and every byte is bit-inverted in both directions. The two interrupt inputs are active-high.

The host polls a busy flag between transfers. Each wait for the module has a host-programmable cycle limit. When the limit runs out, the transfer is abandoned and an error flag is raised. The Ready input and both interrupt inputs pass through two-flop synchronisers before any logic uses them.

Top module: `tbus_ctrl`

Host register map, indexed by `host_addr`:
- 0: module select. A write takes the module number from bits [3:0] and marks the selection valid. A read returns {3'b0, valid, number}.
- 1: command. A write takes a code from bits [3:0]: 1 = initialize, 2 = read (sub-register in bits [6:4]), 3 = clear selection. A read returns status {4'b0, cc, srq, err, busy}.
- 2: output byte. A write starts a byte write. A read returns the stored byte.
- 3: A write sets the wait limit in cycles. A read returns the captured input byte.

## Requirements
- R1: During a byte write, `bus_dq_oe` is high only while `bus_rcv_n` is low, and `bus_dq_out_n` then carries the bitwise complement of the byte written to register 2 (0xD5 appears as 0x2A).
- R2: A read command (code 2) drives `bus_xmt_n` low and puts the complement of bits [6:4] on `bus_sub_n`. The complement of the byte on `bus_dq_in_n` is captured and can be read back from register 3 (raw 0x33 reads as 0xCC).
- R3: With a valid selection of module k, exactly bit k of `bus_sel_n` is low. After reset or after command code 3, every bit of `bus_sel_n` is high.
- R4: An initialize, read or write issued with no valid selection drives no strobe, leaves busy at 0, and sets err (status bit 1).
- R5: Initialize (code 1) holds `bus_init_n` low until Ready (`bus_rdy_n` low) is seen. Busy (status bit 0) stays 1 until the line is released.
- R6: A write waits for Ready before it lowers `bus_rcv_n`. It keeps the strobe low until the module drops Ready, and ends only after Ready returns.
- R7: If a handshake wait outlasts the limit in register 3 (reset value 255), the transfer is abandoned, all lines are released, and err is set. The next accepted transfer clears err.
- R8: While busy is 1, host writes to any register have no effect.
- R9: At most one of `bus_init_n`, `bus_rcv_n`, `bus_xmt_n` is low at a time. In the cycle before busy falls, all strobes are high and `bus_dq_oe` is low.
- R10: `bus_srq` and `bus_cc` are active-high. `host_irq` is set while either one is set. `host_irq_src` is 2'b10 for service request, which wins, and 2'b01 for conversion complete alone. Both also appear as status bits 2 (srq) and 3 (cc).
- R11: After reset, all bus strobes and selects are high, `bus_dq_oe` is low, and status reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| host_wr | input | 1 | Host register write strobe |
| host_addr | input | 2 | Host register index |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data, combinational on host_addr |
| host_irq | output | 1 | Interrupt to host |
| host_irq_src | output | 2 | Interrupt source, priority encoded |
| bus_sel_n | output | 16 | Module select lines, active low |
| bus_init_n | output | 1 | Initialize strobe, active low |
| bus_rcv_n | output | 1 | Receive strobe for writes, active low |
| bus_xmt_n | output | 1 | Transmit strobe for reads, active low |
| bus_sub_n | output | 3 | Sub-register address, active low |
| bus_dq_out_n | output | 8 | Data lines driven toward modules, inverted |
| bus_dq_oe | output | 1 | Drive enable for the data lines |
| bus_dq_in_n | input | 8 | Data lines from modules, inverted |
| bus_rdy_n | input | 1 | Module Ready, active low |
| bus_srq | input | 1 | Service request, active high |
| bus_cc | input | 1 | Conversion complete, active high |

## Verification
The assertions check these on every cycle: the select lines are one-hot or idle, only one strobe is active at a time, data is driven only under Receive, a strobe is active only with a module selected, lines are released before busy drops, and the interrupt output agrees with its source code. The bench scenarios are needed for the rest. These cover the inverted data values in both directions, the decoded select index, the wait for Ready and its abort on timeout, error set and clear, writes ignored while busy, and interrupt priority seen through the synchronisers.

// File: rtl/tbus_ctrl.sv
module tbus_ctrl #(
  parameter int NMOD = 16,
  parameter int DW   = 8,
  parameter int SUBW = 3,
  parameter int TOW  = 8,
  localparam int MW  = $clog2(NMOD)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            host_wr,
  input  logic [1:0]      host_addr,
  input  logic [DW-1:0]   host_wdata,
  output logic [DW-1:0]   host_rdata,
  output logic            host_irq,
  output logic [1:0]      host_irq_src,
  output logic [NMOD-1:0] bus_sel_n,
  output logic            bus_init_n,
  output logic            bus_rcv_n,
  output logic            bus_xmt_n,
  output logic [SUBW-1:0] bus_sub_n,
  output logic [DW-1:0]   bus_dq_out_n,
  output logic            bus_dq_oe,
  input  logic [DW-1:0]   bus_dq_in_n,
  input  logic            bus_rdy_n,
  input  logic            bus_srq,
  input  logic            bus_cc
);

  typedef enum logic [3:0] {
    S_IDLE, S_INIT, S_WRDY, S_WSTB, S_WREC, S_RRDY, S_RSTB, S_RREC, S_DONE
  } st_t;

  st_t state, nxt;
  logic [1:0]      rdy_q, srq_q, cc_q;
  logic            rdy, srq_s, cc_s;
  logic [MW-1:0]   sel;
  logic            sel_vld;
  logic [DW-1:0]   dout, din;
  logic [SUBW-1:0] sub;
  logic            err;
  logic [TOW-1:0]  tmo_lim, cnt;
  logic            busy, waiting, expire, acc;
  logic            go_init, go_read, go_clr, go_wr, go_any;

  assign rdy   = rdy_q[1];
  assign srq_s = srq_q[1];
  assign cc_s  = cc_q[1];

  assign busy    = state != S_IDLE;
  assign acc     = host_wr && !busy;
  assign go_init = acc && host_addr == 2'd1 && host_wdata[3:0] == 4'h1;
  assign go_read = acc && host_addr == 2'd1 && host_wdata[3:0] == 4'h2;
  assign go_clr  = acc && host_addr == 2'd1 && host_wdata[3:0] == 4'h3;
  assign go_wr   = acc && host_addr == 2'd2;
  assign go_any  = go_init || go_read || go_wr;

  assign waiting = state inside {S_INIT, S_WRDY, S_WSTB, S_WREC, S_RRDY, S_RSTB, S_RREC};
  assign expire  = waiting && cnt == tmo_lim;

  always_comb begin
    nxt = state;
    if (expire) nxt = S_DONE;
    else begin
      case (state)
        S_IDLE: begin
          if (sel_vld) begin
            if (go_init)      nxt = S_INIT;
            else if (go_wr)   nxt = S_WRDY;
            else if (go_read) nxt = S_RRDY;
          end
        end
        S_INIT:  if (rdy)  nxt = S_DONE;
        S_WRDY:  if (rdy)  nxt = S_WSTB;
        S_WSTB:  if (!rdy) nxt = S_WREC;
        S_WREC:  if (rdy)  nxt = S_IDLE;
        S_RRDY:  if (rdy)  nxt = S_RSTB;
        S_RSTB:  if (!rdy) nxt = S_RREC;
        S_RREC:  if (rdy)  nxt = S_IDLE;
        S_DONE:  nxt = S_IDLE;
        default: nxt = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdy_q   <= '0;
      srq_q   <= '0;
      cc_q    <= '0;
      state   <= S_IDLE;
      sel     <= '0;
      sel_vld <= 1'b0;
      dout    <= '0;
      din     <= '0;
      sub     <= '0;
      err     <= 1'b0;
      tmo_lim <= '1;
      cnt     <= '0;
    end else begin
      rdy_q <= {rdy_q[0], ~bus_rdy_n};
      srq_q <= {srq_q[0], bus_srq};
      cc_q  <= {cc_q[0], bus_cc};
      state <= nxt;
      cnt   <= (waiting && nxt == state) ? cnt + 1'b1 : '0;
      if (acc && host_addr == 2'd0) begin
        sel     <= host_wdata[MW-1:0];
        sel_vld <= 1'b1;
      end
      if (go_clr) sel_vld <= 1'b0;
      if (acc && host_addr == 2'd3) tmo_lim <= host_wdata[TOW-1:0];
      if (go_wr) dout <= host_wdata;
      if (go_read) sub <= host_wdata[4 +: SUBW];
      if (go_any) err <= !sel_vld;
      if (expire) err <= 1'b1;
      if (state == S_RSTB && !rdy) din <= ~bus_dq_in_n;
    end
  end

  for (genvar i = 0; i < NMOD; i++) begin : g_sel
    assign bus_sel_n[i] = !(sel_vld && sel == MW'(i));
  end

  assign bus_init_n   = state != S_INIT;
  assign bus_rcv_n    = state != S_WSTB;
  assign bus_xmt_n    = state != S_RSTB;
  assign bus_dq_oe    = state == S_WSTB;
  assign bus_dq_out_n = ~dout;
  assign bus_sub_n    = (state inside {S_RRDY, S_RSTB, S_RREC}) ? ~sub : '1;

  assign host_irq     = srq_s || cc_s;
  assign host_irq_src = srq_s ? 2'b10 : (cc_s ? 2'b01 : 2'b00);

  always_comb begin
    case (host_addr)
      2'd0:    host_rdata = {{(DW-MW-1){1'b0}}, sel_vld, sel};
      2'd1:    host_rdata = {{(DW-4){1'b0}}, cc_s, srq_s, err, busy};
      2'd2:    host_rdata = dout;
      default: host_rdata = din;
    endcase
  end

endmodule

// File: rtl/tbus_ctrl_chk.sv
module tbus_ctrl_chk #(
  parameter int NMOD = 16
) (
  input logic            clk,
  input logic            rst,
  input logic            busy,
  input logic [NMOD-1:0] bus_sel_n,
  input logic            bus_init_n,
  input logic            bus_rcv_n,
  input logic            bus_xmt_n,
  input logic            bus_dq_oe,
  input logic            host_irq,
  input logic [1:0]      host_irq_src
);

  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~bus_sel_n)); // R3

  AST_DATA_UNDER_RCV: assert property (@(posedge clk) disable iff (rst)
    bus_dq_oe |-> !bus_rcv_n); // R1

  AST_STROBE_NEEDS_MODULE: assert property (@(posedge clk) disable iff (rst)
    !(bus_init_n && bus_rcv_n && bus_xmt_n) |-> $countones(~bus_sel_n) == 1); // R4

  AST_SINGLE_STROBE: assert property (@(posedge clk) disable iff (rst)
    $countones({~bus_init_n, ~bus_rcv_n, ~bus_xmt_n}) <= 1); // R9

  AST_RELEASE_BEFORE_IDLE: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> $past(bus_init_n && bus_rcv_n && bus_xmt_n && !bus_dq_oe)); // R9

  AST_XMT_ONLY_BUSY: assert property (@(posedge clk) disable iff (rst)
    !bus_xmt_n |-> busy); // R2

  AST_IRQ_MATCHES_SRC: assert property (@(posedge clk) disable iff (rst)
    host_irq == (host_irq_src != 2'b00)); // R10

  AST_IRQ_CODE_LEGAL: assert property (@(posedge clk) disable iff (rst)
    host_irq_src != 2'b11); // R10

endmodule

bind tbus_ctrl tbus_ctrl_chk #(.NMOD(NMOD)) u_chk (
  .clk(clk), .rst(rst), .busy(busy), .bus_sel_n(bus_sel_n),
  .bus_init_n(bus_init_n), .bus_rcv_n(bus_rcv_n), .bus_xmt_n(bus_xmt_n),
  .bus_dq_oe(bus_dq_oe), .host_irq(host_irq), .host_irq_src(host_irq_src)
);

// File: tb/tbus_ctrl_bench.sv
module tbus_ctrl_bench;
  logic        clk = 0;
  logic        rst = 1;
  logic        host_wr = 0;
  logic [1:0]  host_addr = 0;
  logic [7:0]  host_wdata = 0;
  logic [7:0]  host_rdata;
  logic        host_irq;
  logic [1:0]  host_irq_src;
  logic [15:0] bus_sel_n;
  logic        bus_init_n, bus_rcv_n, bus_xmt_n, bus_dq_oe;
  logic [2:0]  bus_sub_n;
  logic [7:0]  bus_dq_out_n;
  logic [7:0]  bus_dq_in_n = 8'hFF;
  logic        bus_rdy_n = 1;
  logic        bus_srq = 0, bus_cc = 0;

  always #4 clk = ~clk;

  tbus_ctrl u_tbus_ctrl (.*);

  int checks = 0, fails = 0, cyc = 0;

  // module model
  logic        m_en = 0;
  logic [7:0]  m_rraw = 0;
  logic [7:0]  cap = 0;
  logic [15:0] cap_sel = 0;
  logic [2:0]  cap_sub = 0;
  logic        early = 0;
  int          nstb = 0, mst = 0, hold = 0;

  always @(negedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++; checks++;
      $display("FAIL watchdog: act=%0d exp=<150000 cycles", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
    case (mst)
      0: begin
        bus_rdy_n = !m_en;
        if (!bus_rcv_n) begin
          cap = bus_dq_out_n; cap_sel = bus_sel_n; nstb++; hold = 4; mst = 1;
        end else if (!bus_xmt_n) begin
          cap_sub = bus_sub_n; bus_dq_in_n = m_rraw; nstb++; hold = 4; mst = 1;
        end
      end
      1: begin
        if (bus_rcv_n && bus_xmt_n) early = 1;
        hold--;
        if (hold == 0) begin bus_rdy_n = 1; mst = 2; end
      end
      default: if (bus_rcv_n && bus_xmt_n) begin bus_rdy_n = !m_en; mst = 0; end
    endcase
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic hwr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); host_addr = a; host_wdata = d; host_wr = 1;
    @(negedge clk); host_wr = 0;
  endtask

  task automatic hrd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); host_addr = a; #1 d = host_rdata;
  endtask

  task automatic wait_idle();
    logic [7:0] s;
    for (int i = 0; i < 2000; i++) begin
      hrd(2'd1, s);
      if (!s[0]) return;
    end
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // {module, write byte, raw read byte, sub-register}
  localparam logic [22:0] VEC [6] = '{
    {4'd0,  8'hD5, 8'h33, 3'd1},
    {4'd15, 8'h00, 8'hFF, 3'd7},
    {4'd9,  8'hFF, 8'h00, 3'd0},
    {4'd5,  8'hA5, 8'h5A, 3'd2},
    {4'd12, 8'h80, 8'h01, 3'd4},
    {4'd3,  8'h7E, 8'hC3, 3'd6}
  };

  initial begin
    logic [7:0] r;
    int n0;
    wait_cyc(5);
    @(negedge clk); rst = 0;

    // R11 reset state
    hrd(2'd1, r);
    chk(r == 8'h00, "R11 status", r, 0);
    chk(bus_sel_n == 16'hFFFF && bus_init_n && bus_rcv_n && bus_xmt_n && !bus_dq_oe,
        "R11 lines", {bus_sel_n, bus_init_n, bus_rcv_n, bus_xmt_n, bus_dq_oe}, 20'hFFFFE);

    // R4 no selection
    m_en = 1; wait_cyc(4);
    n0 = nstb;
    hwr(2'd2, 8'h55); wait_cyc(10);
    hrd(2'd1, r);
    chk(r[1:0] == 2'b10 && nstb == n0, "R4 write without module", r, 2);

    // main vectors: R1 R2 R3
    foreach (VEC[k]) begin
      logic [3:0] md; logic [7:0] wb, rr; logic [2:0] sb;
      {md, wb, rr, sb} = VEC[k];
      hwr(2'd0, {4'h0, md});
      chk(bus_sel_n == ~(16'h1 << md), "R3 select decode", bus_sel_n, ~(16'h1 << md));
      hwr(2'd2, wb); wait_idle();
      chk(cap == ~wb, "R1 inverted write byte", cap, ~wb);
      chk(cap_sel == ~(16'h1 << md), "R3 select during strobe", cap_sel, ~(16'h1 << md));
      chk(early == 0, "R6 strobe held until ready drops", early, 0);
      m_rraw = rr;
      hwr(2'd1, {1'b0, sb, 4'h2}); wait_idle();
      hrd(2'd3, r);
      chk(r == ~rr, "R2 inverted read byte", r, ~rr);
      chk(cap_sub == ~sb, "R2 inverted sub address", cap_sub, ~sb);
      hrd(2'd1, r);
      chk(r[1] == 0, "R7 err clear after good transfer", r[1], 0);
      chk(bus_rcv_n && bus_xmt_n && !bus_dq_oe, "R9 released after transfer",
          {bus_rcv_n, bus_xmt_n, bus_dq_oe}, 3'b110);
    end

    // R6 write waits for ready
    m_en = 0; wait_cyc(4);
    hwr(2'd2, 8'h3C); wait_cyc(10);
    chk(bus_rcv_n == 1, "R6 no strobe before ready", bus_rcv_n, 1);
    m_en = 1; wait_idle();
    chk(cap == 8'hC3, "R6 write completes after ready", cap, 8'hC3);

    // R5 initialize
    m_en = 0; wait_cyc(4);
    hwr(2'd1, 8'h01); wait_cyc(10);
    chk(bus_init_n == 0, "R5 init held low", bus_init_n, 0);
    hrd(2'd1, r);
    chk(r[0] == 1, "R5 busy during init", r[0], 1);
    m_en = 1; wait_idle();
    hrd(2'd1, r);
    chk(r[1:0] == 2'b00 && bus_init_n, "R5 init done", r, 0);

    // R8 writes ignored while busy
    m_en = 0; wait_cyc(4);
    hwr(2'd2, 8'h96); wait_cyc(3);
    hwr(2'd2, 8'h11);
    hwr(2'd0, 8'h01);
    hwr(2'd3, 8'h02);
    hrd(2'd2, r);
    chk(r == 8'h96, "R8 data ignored while busy", r, 8'h96);
    hrd(2'd0, r);
    chk(r == 8'h13, "R8 select ignored while busy", r, 8'h13);
    wait_cyc(40);
    hrd(2'd1, r);
    chk(r[0] == 1, "R8 limit unchanged while busy", r[0], 1);
    wait_idle();
    hrd(2'd1, r);
    chk(r[1] == 1, "R7 abort at default limit", r, 2);

    // R7 timeout with programmed limit
    hwr(2'd3, 8'd20);
    hwr(2'd2, 8'h5A); wait_cyc(8);
    hrd(2'd1, r);
    chk(r[0] == 1, "R7 still waiting below limit", r[0], 1);
    wait_cyc(30);
    hrd(2'd1, r);
    chk(r[1:0] == 2'b10, "R7 abort sets err", r, 2);
    chk(bus_rcv_n && bus_init_n && bus_xmt_n && !bus_dq_oe, "R7 lines released",
        {bus_rcv_n, bus_init_n, bus_xmt_n, bus_dq_oe}, 4'hE);
    m_en = 1; wait_cyc(4);
    hwr(2'd2, 8'h5A); wait_idle();
    hrd(2'd1, r);
    chk(r[1] == 0 && cap == 8'hA5, "R7 err cleared by next transfer", r, 0);

    // R3 clear selection
    hwr(2'd1, 8'h03);
    chk(bus_sel_n == 16'hFFFF, "R3 clear drops select", bus_sel_n, 16'hFFFF);

    // R10 interrupts
    bus_srq = 1; bus_cc = 1; wait_cyc(4);
    hrd(2'd1, r);
    chk(host_irq && host_irq_src == 2'b10 && r[3:2] == 2'b11, "R10 srq wins",
        {host_irq, host_irq_src, r[3:2]}, 5'b11011);
    bus_srq = 0; wait_cyc(4);
    chk(host_irq && host_irq_src == 2'b01, "R10 cc alone", host_irq_src, 1);
    bus_cc = 0; wait_cyc(4);
    chk(!host_irq && host_irq_src == 2'b00, "R10 no irq", host_irq, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule